// File: doc/BRIEF.md
# Boot Fetch Guard

This block lets a processor start from uninitialized RAM on a board that has no boot ROM. A reset from the host bus sets a sticky "boot pending" flag. The flag also tells the rest of the board to hold in its initialization state. While the flag is set, every instruction fetch the processor makes gets a fixed branch-to-self opcode on its data bus instead of memory data. The first fetch after reset comes from address 0, so the processor flushes its prefetch queue there and spins in a tight loop. It never runs arbitrary RAM contents.

Host loader software loads RAM and then clears the flag with a pulse on a dedicated control line. That line is shared with the memory refresh-inhibit control. The flag clears on the rising edge of that pulse, not on its level. A line stuck high therefore cannot hold the flag down once the flag has been set again.

The same logic also serves as a small read-only input port. A decoded read of its address returns four serial-line status inputs. The host-side lines are asynchronous, so each passes through a synchronizer of configurable depth before it reaches the flag.

Top module: `boot_fetch_guard`

## Requirements
- R1: While `rst_n` is low, `boot_pending_o` is 1 from the first clock edge on. With no bus cycle, `ovr_en_o` and `stat_en_o` are 0.
- R2: A high level on `host_rst_i` sets `boot_pending_o` on the third rising clock edge after it is first sampled (two synchronizer stages plus the flag). A single-cycle pulse is enough. The flag stays set after `host_rst_i` returns low.
- R3: While the flag is set, a fetch read (`cpu_rd_i`=1, `cpu_fetch_i`=1, `cpu_wr_i`=0) raises `ovr_en_o` in the same cycle. `ovr_data_o` then equals `BOOT_OP` (default 8'hEA).
- R4: A read with `cpu_fetch_i`=0 never raises `ovr_en_o`. Whenever `ovr_en_o` is 0, `ovr_data_o` is all zeros.
- R5: A cycle with `cpu_wr_i`=1 never raises `ovr_en_o` or `stat_en_o`, even when `cpu_rd_i` and `cpu_fetch_i` are also high.
- R6: A rising edge on `clr_pulse_i` clears the flag on the third rising clock edge after the line is first sampled high. A single-cycle pulse is enough.
- R7: Holding `clr_pulse_i` high has no effect beyond its first rising edge. If the host sets the flag again while the line stays high, the flag remains set until a new rising edge arrives.
- R8: When a host reset and a clear edge reach the flag in the same cycle, the host reset wins and the flag is set.
- R9: While the flag is clear, fetch reads leave `ovr_en_o` at 0, so RAM data passes through.
- R10: A read (`cpu_rd_i`=1, `cpu_wr_i`=0) with `stat_sel_i`=1 raises `stat_en_o` in the same cycle, with `stat_data_o` equal to `line_stat_i`, whatever the flag holds. Otherwise `stat_en_o` is 0 and `stat_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Synchronous active-low chip reset; sets the flag |
| host_rst_i | input | 1 | Host bus reset, asynchronous, active high |
| clr_pulse_i | input | 1 | Loader clear / refresh-inhibit line, asynchronous |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_fetch_i | input | 1 | Current read is an instruction fetch |
| stat_sel_i | input | 1 | Status port address decoded |
| line_stat_i | input | STAT_W | Serial-line status inputs |
| ovr_en_o | output | 1 | Data bus override enable |
| ovr_data_o | output | OP_W | Override byte |
| stat_en_o | output | 1 | Status port drive enable |
| stat_data_o | output | STAT_W | Status port data |
| boot_pending_o | output | 1 | Latched power-on flag |

## Verification
The override path is driven with four kinds of cycle: fetch reads, plain data reads, writes, and cycles with read and write both high. This shows that only a true fetch read is replaced, and only while the flag is set. The clear line is exercised in three ways:
- a held level, which checks the edge latency and shows the line has no further effect;
- a one-cycle pulse;
- a rising edge that coincides with a host reset, which tells set priority from clear priority.

A host reset issued while the clear line is stuck high shows that edge detection, rather than level sensing, guards the flag. Status reads use varying line patterns with the flag both set and clear, along with writes and unselected reads.

// File: rtl/bfg_pkg.sv
// Package: shared types for the boot fetch guard.
// Assumes one CPU bus cycle is described by its read, write and fetch strobes.
package bfg_pkg;

    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
    } cpu_cyc_t;

    // A cycle counts as a read only when the write strobe is low.
    function automatic logic is_read(cpu_cyc_t c);
        return c.rd & ~c.wr;
    endfunction

endpackage

// File: rtl/bfg_sync.sv
// Module: bfg_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// STAGES = 0 selects a plain wire for inputs that are already synchronous.
// Assumes a synchronous active-low reset; every stage resets to RST_VAL.
module bfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] stg;

            // Shift the input along the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg <= {STAGES{RST_VAL}};
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bfg_boot_flag.sv
// Module: bfg_boot_flag
// Sticky boot-pending flag. It is set by chip reset or by the synchronized
// host reset, and cleared only by a rising edge of the synchronized clear
// line. Set wins over clear. The edge history resets high, so a line already
// high when reset ends does not count as an edge.
module bfg_boot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic host_set,
    input  logic clr_lvl,
    output logic pending,
    output logic clr_edge
);

    logic clr_prev;

    // A rising edge is the line high now and low one cycle earlier.
    assign clr_edge = clr_lvl & ~clr_prev;

    // Hold the flag and the previous clear level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b1;
            clr_prev <= 1'b1;
        end else begin
            clr_prev <= clr_lvl;
            if (host_set) begin
                pending <= 1'b1;
            end else if (clr_edge) begin
                pending <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bfg_fetch_override.sv
// Module: bfg_fetch_override
// Replaces fetched instruction data with BOOT_OP while the flag is set.
// Assumes the board mux selects ovr_data over RAM data whenever ovr_en is high.
module bfg_fetch_override
    import bfg_pkg::*;
#(
    parameter int              OP_W    = 8,
    parameter logic [OP_W-1:0] BOOT_OP = 8'hEA
) (
    input  logic            pending,
    input  cpu_cyc_t        cyc,
    output logic            ovr_en,
    output logic [OP_W-1:0] ovr_data
);

    // Override only a true fetch read during boot; otherwise drive zeros.
    always_comb begin
        ovr_en   = pending & cyc.fetch & is_read(cyc);
        ovr_data = ovr_en ? BOOT_OP : '0;
    end

endmodule

// File: rtl/bfg_stat_port.sv
// Module: bfg_stat_port
// Read-only input port returning the serial-line status bits.
// Assumes the enable models a tri-state driver; data is zero when not enabled.
module bfg_stat_port
    import bfg_pkg::*;
#(
    parameter int STAT_W = 4
) (
    input  logic              sel,
    input  cpu_cyc_t          cyc,
    input  logic [STAT_W-1:0] lines,
    output logic              en,
    output logic [STAT_W-1:0] data
);

    // Drive the status lines only on a decoded read.
    always_comb begin
        en   = sel & is_read(cyc);
        data = en ? lines : '0;
    end

endmodule

// File: rtl/boot_fetch_guard.sv
// Module: boot_fetch_guard (top)
// Latches a power-on flag from the host reset, feeds a branch-to-self opcode
// to CPU fetches while the flag is set, and provides a small status port.
// Assumes host_rst_i and clr_pulse_i are asynchronous; CPU strobes are
// synchronous to clk.
module boot_fetch_guard
    import bfg_pkg::*;
#(
    parameter int              OP_W        = 8,
    parameter logic [OP_W-1:0] BOOT_OP     = 8'hEA,
    parameter int              STAT_W      = 4,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst_i,
    input  logic              clr_pulse_i,
    input  logic              cpu_rd_i,
    input  logic              cpu_wr_i,
    input  logic              cpu_fetch_i,
    input  logic              stat_sel_i,
    input  logic [STAT_W-1:0] line_stat_i,
    output logic              ovr_en_o,
    output logic [OP_W-1:0]   ovr_data_o,
    output logic              stat_en_o,
    output logic [STAT_W-1:0] stat_data_o,
    output logic              boot_pending_o
);

    logic     host_sync;
    logic     clr_sync;
    logic     clr_edge;
    logic     pending;
    cpu_cyc_t cyc;

    // Collect the CPU strobes into one bus-cycle descriptor.
    always_comb begin
        cyc.rd    = cpu_rd_i;
        cyc.wr    = cpu_wr_i;
        cyc.fetch = cpu_fetch_i;
    end

    bfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_host_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (host_rst_i),
        .q     (host_sync)
    );

    bfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (clr_pulse_i),
        .q     (clr_sync)
    );

    bfg_boot_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_set (host_sync),
        .clr_lvl  (clr_sync),
        .pending  (pending),
        .clr_edge (clr_edge)
    );

    bfg_fetch_override #(.OP_W(OP_W), .BOOT_OP(BOOT_OP)) u_ovr (
        .pending  (pending),
        .cyc      (cyc),
        .ovr_en   (ovr_en_o),
        .ovr_data (ovr_data_o)
    );

    bfg_stat_port #(.STAT_W(STAT_W)) u_stat (
        .sel   (stat_sel_i),
        .cyc   (cyc),
        .lines (line_stat_i),
        .en    (stat_en_o),
        .data  (stat_data_o)
    );

    assign boot_pending_o = pending;

endmodule

// File: rtl/boot_fetch_guard_chk.sv
// Module: boot_fetch_guard_chk
// Property checker bound into boot_fetch_guard. It relates the ports to the
// synchronized set and clear-edge signals inside the top module.
module boot_fetch_guard_chk #(
    parameter int              OP_W    = 8,
    parameter logic [OP_W-1:0] BOOT_OP = 8'hEA,
    parameter int              STAT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd_i,
    input logic              cpu_wr_i,
    input logic              cpu_fetch_i,
    input logic [STAT_W-1:0] line_stat_i,
    input logic              ovr_en_o,
    input logic [OP_W-1:0]   ovr_data_o,
    input logic              stat_en_o,
    input logic [STAT_W-1:0] stat_data_o,
    input logic              boot_pending_o,
    input logic              host_sync,
    input logic              clr_edge
);

    a_r1_reset_sets: assert property (@(posedge clk)
        !rst_n |=> boot_pending_o);

    a_r2_set_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_pending_o) |-> $past(host_sync));

    a_r3_fetch_gets_op: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_pending_o && cpu_rd_i && cpu_fetch_i && !cpu_wr_i)
            |-> (ovr_en_o && ovr_data_o == BOOT_OP));

    a_r4_nonfetch_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_fetch_i |-> (!ovr_en_o && ovr_data_o == '0));

    a_r5_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_i |-> (!ovr_en_o && !stat_en_o));

    a_r6_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boot_pending_o) |-> ($past(clr_edge) && !$past(host_sync)));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_pending_o |-> !ovr_en_o);

    a_r10_status_data: assert property (@(posedge clk) disable iff (!rst_n)
        stat_en_o |-> (stat_data_o == line_stat_i));

    a_r10_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en_o |-> (stat_data_o == '0));

endmodule

bind boot_fetch_guard boot_fetch_guard_chk #(
    .OP_W    (OP_W),
    .BOOT_OP (BOOT_OP),
    .STAT_W  (STAT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_rd_i       (cpu_rd_i),
    .cpu_wr_i       (cpu_wr_i),
    .cpu_fetch_i    (cpu_fetch_i),
    .line_stat_i    (line_stat_i),
    .ovr_en_o       (ovr_en_o),
    .ovr_data_o     (ovr_data_o),
    .stat_en_o      (stat_en_o),
    .stat_data_o    (stat_data_o),
    .boot_pending_o (boot_pending_o),
    .host_sync      (host_sync),
    .clr_edge       (clr_edge)
);

// File: tb/tb_boot_fetch_guard.sv
// Scoreboard bench. The driver task sets one cycle of inputs on the falling
// edge and queues the expected outputs. The monitor pops and compares 1 ns
// later, away from the rising edge.
module tb_boot_fetch_guard;

    localparam logic [7:0] OPV = 8'hEA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rst_i = 1'b0;
    logic       clr_pulse_i = 1'b0;
    logic       cpu_rd_i = 1'b0;
    logic       cpu_wr_i = 1'b0;
    logic       cpu_fetch_i = 1'b0;
    logic       stat_sel_i = 1'b0;
    logic [3:0] line_stat_i = 4'h0;
    logic       ovr_en_o;
    logic [7:0] ovr_data_o;
    logic       stat_en_o;
    logic [3:0] stat_data_o;
    logic       boot_pending_o;

    // 125 MHz clock.
    always #4 clk = ~clk;

    boot_fetch_guard dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_rst_i     (host_rst_i),
        .clr_pulse_i    (clr_pulse_i),
        .cpu_rd_i       (cpu_rd_i),
        .cpu_wr_i       (cpu_wr_i),
        .cpu_fetch_i    (cpu_fetch_i),
        .stat_sel_i     (stat_sel_i),
        .line_stat_i    (line_stat_i),
        .ovr_en_o       (ovr_en_o),
        .ovr_data_o     (ovr_data_o),
        .stat_en_o      (stat_en_o),
        .stat_data_o    (stat_data_o),
        .boot_pending_o (boot_pending_o)
    );

    typedef struct {
        logic       en;
        logic [7:0] d;
        logic       sen;
        logic [3:0] sd;
        logic       fl;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t m_e;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Driver: apply one cycle and queue the expected outputs from the requirements.
    task automatic cyc(input logic h, input logic c, input logic rd,
                       input logic fe, input logic wr, input logic sel,
                       input logic [3:0] ln, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        host_rst_i  = h;
        clr_pulse_i = c;
        cpu_rd_i    = rd;
        cpu_fetch_i = fe;
        cpu_wr_i    = wr;
        stat_sel_i  = sel;
        line_stat_i = ln;
        e.en  = ef & rd & fe & ~wr;
        e.d   = e.en ? OPV : 8'h00;
        e.sen = sel & rd & ~wr;
        e.sd  = e.sen ? ln : 4'h0;
        e.fl  = ef;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare every queued expectation with the outputs.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            m_e = q.pop_front();
            checks++;
            if (ovr_en_o !== m_e.en || ovr_data_o !== m_e.d || stat_en_o !== m_e.sen ||
                stat_data_o !== m_e.sd || boot_pending_o !== m_e.fl) begin
                errors++;
                $display("FAIL %s: got en=%b d=%h sen=%b sd=%h flag=%b, expected en=%b d=%h sen=%b sd=%h flag=%b",
                         m_e.tag, ovr_en_o, ovr_data_o, stat_en_o, stat_data_o, boot_pending_o,
                         m_e.en, m_e.d, m_e.sen, m_e.sd, m_e.fl);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: state during chip reset
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 1, "R1 reset idle");
        cyc(0, 0, 1, 1, 0, 0, 4'h0, 1, "R1 fetch in reset");
        rst_n = 1'b1;
        // R3, R4, R5: override filtering with flag set
        cyc(0, 0, 1, 1, 0, 0, 4'h0, 1, "R3 fetch override");
        cyc(0, 0, 1, 0, 0, 0, 4'h0, 1, "R4 data read");
        cyc(0, 0, 0, 1, 1, 0, 4'h0, 1, "R5 fetch-flagged write");
        cyc(0, 0, 1, 1, 1, 1, 4'h9, 1, "R5 rd and wr both high");
        // R10: status port
        cyc(0, 0, 1, 0, 0, 1, 4'hA, 1, "R10 status read");
        cyc(0, 0, 0, 0, 1, 1, 4'h5, 1, "R10 status write");
        cyc(0, 0, 1, 0, 0, 0, 4'h3, 1, "R10 unselected read");
        // R6: clear held high, flag drops on third edge
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R6 clear c0");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R6 clear c1");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R6 clear c2");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 0, "R6 cleared c3");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 0, "R9 fetch passes through");
        cyc(0, 1, 1, 0, 0, 1, 4'h6, 0, "R10 status with flag clear");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 0, "R7 clear held high");
        // R2 and R7: host reset pulse while clear stays high
        cyc(1, 1, 1, 1, 0, 0, 4'h0, 0, "R2 host h0");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 0, "R2 host h1");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 0, "R2 host h2");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R2 host set h3");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R7 stuck clear no effect");
        cyc(0, 1, 0, 0, 0, 0, 4'h0, 1, "R2 sticky");
        // R8: set wins over coincident clear edge
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 1, "R8 prep");
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 1, "R8 prep");
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 1, "R8 prep");
        cyc(1, 1, 1, 1, 0, 0, 4'h0, 1, "R8 p0");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R8 p1");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R8 p2");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R8 set wins p3");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R7 no new edge");
        // R6: single-cycle clear pulse
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 1, "R6 prep");
        cyc(0, 0, 0, 0, 0, 0, 4'h0, 1, "R6 prep");
        cyc(0, 1, 1, 1, 0, 0, 4'h0, 1, "R6 pulse q0");
        cyc(0, 0, 1, 1, 0, 0, 4'h0, 1, "R6 pulse q1");
        cyc(0, 0, 1, 1, 0, 0, 4'h0, 1, "R6 pulse q2");
        cyc(0, 0, 1, 1, 0, 0, 4'h0, 0, "R6 pulse cleared q3");
        cyc(0, 0, 1, 0, 0, 1, 4'hF, 0, "R10 status all ones");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule